// File: doc/BRIEF.md
# Power-Management Command SMI Controller

This block turns a write of an eight-bit command into either an ACPI mode change or a system-management interrupt (SMI). The two ACPI command codes 0xF0 and 0xF1 set and clear an ACPI-mode flag and never raise an SMI. Every other code raises an SMI, but only when the APM enable bit (bit 5) of the SMI enable register is set. The SMI is a one-cycle pulse on a per-CPU vector. It is sent only to the CPU whose index comes with the command, unless the negotiated feature set contains the broadcast feature (bit 0). In that case every CPU is pulsed.

Software negotiates features by writing a 64-bit request one byte at a time, in little-endian order, and then strobing a confirm input. The block compares the request against a host-supported mask given as a parameter. It accepts the request only if the request is a subset of that mask. Once accepted, the result is locked until reset.

A power-management control register carries a lock bit. Once software sets that bit, it can no longer be cleared, and bit 0 of the SMI enable register is frozen.

Top module: `apm_smi_ctrl`

## Requirements
- R1: A command with code 0xF0 sets `acpi_mode` to 1 in the cycle after the command and raises no SMI.
- R2: A command with code 0xF1 clears `acpi_mode` in the cycle after the command and raises no SMI.
- R3: For any other code, an SMI is raised in the cycle after the command only when `smi_en` bit 5 is 1. It lasts exactly one cycle, and `acpi_mode` is left unchanged. When bit 5 is 0, no SMI is raised.
- R4: When bit 0 of `negotiated` is 0, a raised SMI sets only bit `cmd_cpu` of `smi_out`.
- R5: When bit 0 of `negotiated` is 1, a raised SMI sets every bit of `smi_out`.
- R6: A confirm strobe while `feat_ok` is 0 sets `feat_ok` and copies the request into `negotiated`, but only if the request has no bit outside the host mask (default 0x1). Otherwise both outputs stay unchanged.
- R7: While `feat_ok` is 1, confirm strobes are ignored and `negotiated` keeps its value. Request bytes can still be written.
- R8: A request byte write with index i places the byte at bits 8i+7..8i of `req_word`.
- R9: Reset clears `req_word`, `feat_ok`, `negotiated`, `acpi_mode`, `smi_out`, `smi_en` and `pmcon`.
- R10: Once `pmcon` bit 4 is 1, writes cannot clear it, and `smi_en` bit 0 keeps its value across writes. All other bits of both registers remain writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| cmd_cpu | input | CPU_W | Index of the CPU issuing the command |
| smi_en_we | input | 1 | SMI enable register write strobe |
| smi_en_wdata | input | SMI_EN_W | SMI enable write data |
| pmcon_we | input | 1 | PM control register write strobe |
| pmcon_wdata | input | PMCON_W | PM control write data |
| req_we | input | 1 | Feature request byte write strobe |
| req_idx | input | IDX_W | Byte index of the request write |
| req_byte | input | 8 | Request byte data |
| ok_strobe | input | 1 | Negotiation confirm strobe |
| smi_out | output | N_CPU | Per-CPU SMI pulses |
| acpi_mode | output | 1 | ACPI mode flag |
| smi_en | output | SMI_EN_W | SMI enable register |
| pmcon | output | PMCON_W | PM control register |
| req_word | output | FEAT_W | Assembled feature request |
| feat_ok | output | 1 | Negotiation accepted and locked |
| negotiated | output | FEAT_W | Locked negotiated features |

## Verification
The bench issues all 256 command codes from every CPU index in three settings: APM enable off, APM enable on before any negotiation, and APM enable on after broadcast has been negotiated. These three sweeps separate the ACPI codes from the SMI codes. They also separate gating by the enable bit from the choice between single-target and broadcast delivery, and the idle cycle after each command confirms the pulse is one cycle wide. Negotiation is tried first with a request that falls outside the host mask, then with a valid one, then with a different request after locking. This shows that acceptance depends only on the subset test and that the lock holds. Lock-bit writes are made both before and after locking, so the frozen SMI enable bit can be told apart from ordinary write behaviour.

// File: rtl/apm_smi_pkg.sv
package apm_smi_pkg;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_ACPI_ON,
        CMD_ACPI_OFF,
        CMD_SMI
    } cmd_kind_e;

    function automatic cmd_kind_e classify_cmd(
        input logic       valid,
        input logic [7:0] code,
        input logic [7:0] on_code,
        input logic [7:0] off_code
    );
        if (!valid)              return CMD_NONE;
        else if (code == on_code)  return CMD_ACPI_ON;
        else if (code == off_code) return CMD_ACPI_OFF;
        else                       return CMD_SMI;
    endfunction

endpackage

// File: rtl/apm_pm_regs.sv
module apm_pm_regs #(
    parameter int SMI_EN_W = 32,
    parameter int PMCON_W  = 16,
    parameter int LOCK_BIT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smi_en_we,
    input  logic [SMI_EN_W-1:0] smi_en_wdata,
    input  logic                pmcon_we,
    input  logic [PMCON_W-1:0]  pmcon_wdata,
    output logic [SMI_EN_W-1:0] smi_en,
    output logic [PMCON_W-1:0]  pmcon
);
    typedef struct packed {
        logic [SMI_EN_W-1:0] smi;
        logic [PMCON_W-1:0]  pm;
    } regs_t;

    regs_t st_d, st_q;
    logic  locked;

    assign locked = st_q.pm[LOCK_BIT];

    always_comb begin
        st_d = st_q;
        if (pmcon_we) begin
            st_d.pm = pmcon_wdata;
            if (locked) st_d.pm[LOCK_BIT] = 1'b1;
        end
        if (smi_en_we) begin
            st_d.smi = smi_en_wdata;
            if (locked) st_d.smi[0] = st_q.smi[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smi_en = st_q.smi;
    assign pmcon  = st_q.pm;

    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pmcon[LOCK_BIT] |=> pmcon[LOCK_BIT]);

    // R10
    smi_bit0_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pmcon[LOCK_BIT] |=> $stable(smi_en[0]));

endmodule

// File: rtl/apm_feat_neg.sv
module apm_feat_neg #(
    parameter int                FEAT_W    = 64,
    parameter int                IDX_W     = 3,
    parameter logic [FEAT_W-1:0] HOST_MASK = 64'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_we,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [7:0]        req_byte,
    input  logic              ok_strobe,
    output logic [FEAT_W-1:0] req_word,
    output logic              feat_ok,
    output logic [FEAT_W-1:0] negotiated
);
    localparam int NBYTES = FEAT_W / 8;

    typedef struct packed {
        logic [FEAT_W-1:0] req;
        logic              ok;
        logic [FEAT_W-1:0] neg;
    } neg_t;

    neg_t st_d, st_q;
    logic subset;

    assign subset = ((st_q.req & ~HOST_MASK) == '0);

    always_comb begin
        st_d = st_q;
        if (req_we) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (req_idx == IDX_W'(b)) st_d.req[b*8 +: 8] = req_byte;
            end
        end
        if (ok_strobe && !st_q.ok && subset) begin
            st_d.ok  = 1'b1;
            st_d.neg = st_q.req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_word   = st_q.req;
    assign feat_ok    = st_q.ok;
    assign negotiated = st_q.neg;

    // R7
    neg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feat_ok |=> (feat_ok && $stable(negotiated)));

    // R6
    neg_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feat_ok |-> ((negotiated & ~HOST_MASK) == '0));

    // R6
    neg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(feat_ok) |-> $past(ok_strobe));

endmodule

// File: rtl/apm_cmd_dec.sv
module apm_cmd_dec
    import apm_smi_pkg::*;
#(
    parameter int         N_CPU    = 4,
    parameter int         CPU_W    = 2,
    parameter logic [7:0] ON_CODE  = 8'hF0,
    parameter logic [7:0] OFF_CODE = 8'hF1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    input  logic [CPU_W-1:0] cmd_cpu,
    input  logic             apm_en,
    input  logic             bcast,
    output logic             acpi_mode,
    output logic [N_CPU-1:0] smi_out
);
    typedef struct packed {
        logic             acpi;
        logic [N_CPU-1:0] smi;
    } dec_t;

    dec_t             st_d, st_q;
    cmd_kind_e        kind;
    logic [N_CPU-1:0] target;

    for (genvar g = 0; g < N_CPU; g++) begin : g_target
        assign target[g] = bcast | (cmd_cpu == CPU_W'(g));
    end

    assign kind = classify_cmd(cmd_valid, cmd_code, ON_CODE, OFF_CODE);

    always_comb begin
        st_d     = st_q;
        st_d.smi = '0;
        case (kind)
            CMD_ACPI_ON:  st_d.acpi = 1'b1;
            CMD_ACPI_OFF: st_d.acpi = 1'b0;
            CMD_SMI:      if (apm_en) st_d.smi = target;
            default:      ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acpi_mode = st_q.acpi;
    assign smi_out   = st_q.smi;

    // R1
    acpi_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == ON_CODE) |=> (acpi_mode && smi_out == '0));

    // R2
    acpi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OFF_CODE) |=> (!acpi_mode && smi_out == '0));

    // R3
    smi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|smi_out) |-> $past(cmd_valid && apm_en));

    // R4
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|smi_out) && !$past(bcast)) |-> $onehot(smi_out));

endmodule

// File: rtl/apm_smi_ctrl.sv
module apm_smi_ctrl #(
    parameter int                N_CPU      = 4,
    parameter int                SMI_EN_W   = 32,
    parameter int                PMCON_W    = 16,
    parameter int                FEAT_W     = 64,
    parameter int                APM_EN_BIT = 5,
    parameter int                LOCK_BIT   = 4,
    parameter int                BCAST_BIT  = 0,
    parameter logic [7:0]        ON_CODE    = 8'hF0,
    parameter logic [7:0]        OFF_CODE   = 8'hF1,
    parameter logic [FEAT_W-1:0] HOST_MASK  = 64'h1,
    localparam int               CPU_W      = (N_CPU > 1) ? $clog2(N_CPU) : 1,
    localparam int               IDX_W      = $clog2(FEAT_W / 8)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_code,
    input  logic [CPU_W-1:0]    cmd_cpu,
    input  logic                smi_en_we,
    input  logic [SMI_EN_W-1:0] smi_en_wdata,
    input  logic                pmcon_we,
    input  logic [PMCON_W-1:0]  pmcon_wdata,
    input  logic                req_we,
    input  logic [IDX_W-1:0]    req_idx,
    input  logic [7:0]          req_byte,
    input  logic                ok_strobe,
    output logic [N_CPU-1:0]    smi_out,
    output logic                acpi_mode,
    output logic [SMI_EN_W-1:0] smi_en,
    output logic [PMCON_W-1:0]  pmcon,
    output logic [FEAT_W-1:0]   req_word,
    output logic                feat_ok,
    output logic [FEAT_W-1:0]   negotiated
);

    apm_pm_regs #(
        .SMI_EN_W (SMI_EN_W),
        .PMCON_W  (PMCON_W),
        .LOCK_BIT (LOCK_BIT)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .smi_en_we    (smi_en_we),
        .smi_en_wdata (smi_en_wdata),
        .pmcon_we     (pmcon_we),
        .pmcon_wdata  (pmcon_wdata),
        .smi_en       (smi_en),
        .pmcon        (pmcon)
    );

    apm_feat_neg #(
        .FEAT_W    (FEAT_W),
        .IDX_W     (IDX_W),
        .HOST_MASK (HOST_MASK)
    ) u_neg (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_we     (req_we),
        .req_idx    (req_idx),
        .req_byte   (req_byte),
        .ok_strobe  (ok_strobe),
        .req_word   (req_word),
        .feat_ok    (feat_ok),
        .negotiated (negotiated)
    );

    apm_cmd_dec #(
        .N_CPU    (N_CPU),
        .CPU_W    (CPU_W),
        .ON_CODE  (ON_CODE),
        .OFF_CODE (OFF_CODE)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_cpu   (cmd_cpu),
        .apm_en    (smi_en[APM_EN_BIT]),
        .bcast     (negotiated[BCAST_BIT]),
        .acpi_mode (acpi_mode),
        .smi_out   (smi_out)
    );

endmodule

// File: tb/tb_apm_smi_ctrl.sv
module tb_apm_smi_ctrl;
    localparam int N_CPU = 4;
    localparam int CPU_W = 2;
    localparam int SW    = 32;
    localparam int PW    = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n;
    logic             cmd_valid;
    logic [7:0]       cmd_code;
    logic [CPU_W-1:0] cmd_cpu;
    logic             smi_en_we;
    logic [SW-1:0]    smi_en_wdata;
    logic             pmcon_we;
    logic [PW-1:0]    pmcon_wdata;
    logic             req_we;
    logic [2:0]       req_idx;
    logic [7:0]       req_byte;
    logic             ok_strobe;
    logic [N_CPU-1:0] smi_out;
    logic             acpi_mode;
    logic [SW-1:0]    smi_en;
    logic [PW-1:0]    pmcon;
    logic [63:0]      req_word;
    logic             feat_ok;
    logic [63:0]      negotiated;

    apm_smi_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_cpu(cmd_cpu),
        .smi_en_we(smi_en_we), .smi_en_wdata(smi_en_wdata),
        .pmcon_we(pmcon_we), .pmcon_wdata(pmcon_wdata),
        .req_we(req_we), .req_idx(req_idx), .req_byte(req_byte),
        .ok_strobe(ok_strobe),
        .smi_out(smi_out), .acpi_mode(acpi_mode), .smi_en(smi_en),
        .pmcon(pmcon), .req_word(req_word), .feat_ok(feat_ok),
        .negotiated(negotiated)
    );

    int   n_checks = 0;
    int   n_errs   = 0;
    bit   finished = 0;
    logic exp_acpi = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_acpi = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] code, input int cpu);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_cpu = CPU_W'(cpu);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wr_smi_en(input logic [SW-1:0] v);
        @(negedge clk); smi_en_we = 1'b1; smi_en_wdata = v;
        @(negedge clk); smi_en_we = 1'b0;
    endtask

    task automatic wr_pmcon(input logic [PW-1:0] v);
        @(negedge clk); pmcon_we = 1'b1; pmcon_wdata = v;
        @(negedge clk); pmcon_we = 1'b0;
    endtask

    task automatic wr_req(input int idx, input logic [7:0] b);
        @(negedge clk); req_we = 1'b1; req_idx = 3'(idx); req_byte = b;
        @(negedge clk); req_we = 1'b0;
    endtask

    task automatic confirm();
        @(negedge clk); ok_strobe = 1'b1;
        @(negedge clk); ok_strobe = 1'b0;
    endtask

    task automatic sweep(input logic apm, input logic bc);
        for (int code = 0; code < 256; code++) begin
            for (int cpu = 0; cpu < N_CPU; cpu++) begin
                logic [N_CPU-1:0] e;
                string tag;
                e = '0;
                if (code == 8'hF0) begin
                    exp_acpi = 1'b1; tag = "R1";
                end else if (code == 8'hF1) begin
                    exp_acpi = 1'b0; tag = "R2";
                end else if (!apm) begin
                    tag = "R3";
                end else begin
                    e   = bc ? '1 : (N_CPU'(1) << cpu);
                    tag = bc ? "R5" : "R4";
                end
                send_cmd(8'(code), cpu);
                chk(tag, 64'(smi_out), 64'(e));
                chk(tag, 64'(acpi_mode), 64'(exp_acpi));
                @(negedge clk);
                chk("R3 one-cycle pulse", 64'(smi_out), 64'h0);
            end
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = '0; cmd_cpu = '0;
        smi_en_we = 1'b0; smi_en_wdata = '0; pmcon_we = 1'b0; pmcon_wdata = '0;
        req_we = 1'b0; req_idx = '0; req_byte = '0; ok_strobe = 1'b0;
        do_reset();
        @(negedge clk);
        chk("R9 acpi", 64'(acpi_mode), 64'h0);
        chk("R9 smi", 64'(smi_out), 64'h0);
        chk("R9 smi_en", 64'(smi_en), 64'h0);
        chk("R9 pmcon", 64'(pmcon), 64'h0);
        chk("R9 feat_ok", 64'(feat_ok), 64'h0);

        // R3 gating off, then R1/R2/R4 single-target
        wr_smi_en(32'h0);
        sweep(1'b0, 1'b0);
        wr_smi_en(32'h20);
        sweep(1'b1, 1'b0);

        // R8 byte lanes
        for (int i = 0; i < 8; i++) wr_req(i, 8'hA0 + 8'(i));
        chk("R8 lanes", req_word, 64'hA7A6A5A4A3A2A1A0);
        for (int i = 0; i < 8; i++) wr_req(i, 8'h00);
        wr_req(1, 8'h02);
        wr_req(0, 8'h01);
        chk("R8 word", req_word, 64'h0201);
        // R6 reject outside host mask
        confirm();
        @(negedge clk);
        chk("R6 reject ok", 64'(feat_ok), 64'h0);
        chk("R6 reject neg", negotiated, 64'h0);
        // R6 accept subset
        wr_req(1, 8'h00);
        confirm();
        @(negedge clk);
        chk("R6 accept ok", 64'(feat_ok), 64'h1);
        chk("R6 accept neg", negotiated, 64'h1);
        // R7 locked
        wr_req(0, 8'h00);
        chk("R7 request writable", req_word, 64'h0);
        confirm();
        @(negedge clk);
        chk("R7 ok held", 64'(feat_ok), 64'h1);
        chk("R7 neg held", negotiated, 64'h1);

        // R5 broadcast
        sweep(1'b1, 1'b1);

        // R10 lock bit
        wr_smi_en(32'h21);
        wr_smi_en(32'h20);
        chk("R10 bit0 writable before lock", 64'(smi_en), 64'h20);
        wr_smi_en(32'h21);
        wr_pmcon(16'h0013);
        chk("R10 pmcon set", 64'(pmcon), 64'h13);
        wr_smi_en(32'h20);
        chk("R10 bit0 frozen", 64'(smi_en), 64'h21);
        wr_smi_en(32'hFFFF_FFFE);
        chk("R10 other bits writable", 64'(smi_en), 64'hFFFF_FFFF);
        wr_pmcon(16'h0000);
        chk("R10 lock sticky", 64'(pmcon), 64'h10);

        // R9 reset mid-run
        do_reset();
        @(negedge clk);
        chk("R9 req cleared", req_word, 64'h0);
        chk("R9 ok cleared", 64'(feat_ok), 64'h0);
        chk("R9 neg cleared", negotiated, 64'h0);
        chk("R9 smi_en cleared", 64'(smi_en), 64'h0);
        chk("R9 pmcon cleared", 64'(pmcon), 64'h0);
        chk("R9 acpi cleared", 64'(acpi_mode), 64'h0);

        finished = 1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
            $finish;
        end
    end

endmodule